// File: doc/BRIEF.md
# Flash Command Register State Machine

This block is the command front end of a byte-wide parallel flash memory. A microprocessor-style bus (active-low chip enable, write enable and output enable, plus address and data) writes bytes into a command register. The block decodes one- and two-write command sequences. The decoded mode then selects what a bus read returns: array contents, identifier codes, or verify data taken from an address that was latched earlier. Valid sequences issue erase-start and program-start strobes to an on-block array model, which applies each operation after a fixed, parameterised latency and reports busy while it runs.

The bus pins are sampled on the block clock and must be synchronous to it. On a bus write, the address is captured when write enable falls and the data byte when it rises. A programming-supply-good input gates the command path: while it is low the block stays in read-array mode and ignores every write.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset, every array byte reads FFH and the block is in read-array mode. Whenever vpp_hi_i has been low, the block returns to read-array mode.
- R2: While vpp_hi_i is low, command writes have no effect: no mode change, no erase, no program.
- R3: Writing 00H selects read-array mode, and reads at any address return that array byte until another command is written.
- R4: Writing 90H selects identifier mode. A read at address 0 returns 89H, a read at address 1 returns BDH, and a read at any other address returns 00H.
- R5: Two consecutive writes of 20H start an erase. busy_o is high for exactly ERASE_LAT clock cycles, after which every byte reads FFH.
- R6: 20H followed by any other byte starts no erase, leaves the array unchanged and returns the block to read-array mode.
- R7: Writing A0H selects erase verify. The address of that write is latched, and reads return the byte at the latched address whatever address the read uses.
- R8: Writing 40H selects program set-up. The next write starts programming at its own address: busy_o is high for exactly PROG_LAT cycles, after which the byte holds old AND new data.
- R9: Writing C0H selects program verify. Reads return the byte at the most recently programmed address.
- R10: Two writes of FFH, or a write of any undefined code, leave the block in read-array mode.
- R11: The address of a write is taken at the falling edge of we_ni and the data at its rising edge. Changes at other times inside the pulse have no effect.
- R12: A write while busy_o is high stops the running operation at once. The array and the mode are left unchanged.
- R13: data_o is 00H whenever ce_ni or oe_ni is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; bus pins are sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vpp_hi_i | input | 1 | Programming supply good; low forces read-array mode |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | 8 | Bus write data |
| data_o | output | 8 | Bus read data |
| busy_o | output | 1 | Internal erase or program in progress |

## Verification
The hardest case to reach from the ports is a write that arrives during a running erase. The outcome has to be shown by what does not happen. The stimulus starts a long erase over an array that already holds distinct programmed bytes. It then writes during the busy window and keeps running well past the erase latency. Finally it sweeps every address to prove that no byte became FFH. Every bus write also moves the address off its value after the fall of we_ni and holds a decoy data byte until just before the rise. Every programmed and verified location therefore also checks the edge on which each field is captured.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    MODE_READ,
    MODE_ID,
    MODE_ERASE_SET,
    MODE_ERASE_VFY,
    MODE_PROG_SET,
    MODE_PROG_VFY,
    MODE_RESET_SET
  } mode_e;

  localparam logic [7:0] CMD_READ      = 8'h00;
  localparam logic [7:0] CMD_ID        = 8'h90;
  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_ERASE_VFY = 8'hA0;
  localparam logic [7:0] CMD_PROG      = 8'h40;
  localparam logic [7:0] CMD_PROG_VFY  = 8'hC0;
  localparam logic [7:0] CMD_RESET     = 8'hFF;
endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [ADDR_W-1:0] addr_lat_o,
  output logic [7:0]        data_o,
  output logic              commit_o
);
  logic we_q;
  logic we_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b1;
    else         we_q <= we_ni;
  end

  assign we_fall  = we_q & ~we_ni & ~ce_ni;
  // rising edge of we_ni closes the write; data is taken in that cycle
  assign commit_o = ~we_q & we_ni & ~ce_ni;
  assign data_o   = data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_lat_o <= '0;
    else if (we_fall) addr_lat_o <= addr_i;
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vpp_hi_i,
  input  logic              commit_i,
  input  logic [7:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_lat_i,
  input  logic              busy_i,
  output mode_e             mode_o,
  output logic [ADDR_W-1:0] ev_addr_o,
  output logic [ADDR_W-1:0] pv_addr_o,
  output logic              erase_go_o,
  output logic              prog_go_o,
  output logic              abort_o
);
  logic accept;

  assign accept     = vpp_hi_i & commit_i & ~busy_i;
  assign erase_go_o = accept & (mode_o == MODE_ERASE_SET) & (cmd_i == CMD_ERASE);
  assign prog_go_o  = accept & (mode_o == MODE_PROG_SET);
  assign abort_o    = busy_i & (commit_i | ~vpp_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= MODE_READ;
      ev_addr_o <= '0;
      pv_addr_o <= '0;
    end else if (!vpp_hi_i) begin
      mode_o <= MODE_READ;
    end else if (accept) begin
      unique case (mode_o)
        MODE_ERASE_SET: mode_o <= MODE_READ;
        MODE_PROG_SET: begin
          pv_addr_o <= addr_lat_i;
          mode_o    <= MODE_READ;
        end
        MODE_RESET_SET: mode_o <= MODE_READ;
        default: begin
          unique case (cmd_i)
            CMD_ID:        mode_o <= MODE_ID;
            CMD_ERASE:     mode_o <= MODE_ERASE_SET;
            CMD_ERASE_VFY: begin
              mode_o    <= MODE_ERASE_VFY;
              ev_addr_o <= addr_lat_i;
            end
            CMD_PROG:      mode_o <= MODE_PROG_SET;
            CMD_PROG_VFY:  mode_o <= MODE_PROG_VFY;
            CMD_RESET:     mode_o <= MODE_RESET_SET;
            default:       mode_o <= MODE_READ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model #(
  parameter int ADDR_W    = 4,
  parameter int ERASE_LAT = 24,
  parameter int PROG_LAT  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_go_i,
  input  logic              prog_go_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [7:0]        prog_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int LAT_MAX = (ERASE_LAT > PROG_LAT) ? ERASE_LAT : PROG_LAT;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  logic [7:0]        mem [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic              op_erase_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [7:0]        op_data_q;

  assign busy_o    = (cnt_q != '0);
  assign rd_data_o = mem[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      op_erase_q <= 1'b0;
      op_addr_q  <= '0;
      op_data_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (abort_i) begin
      cnt_q <= '0;
    end else if (erase_go_i) begin
      cnt_q      <= CNT_W'(ERASE_LAT);
      op_erase_q <= 1'b1;
    end else if (prog_go_i) begin
      cnt_q      <= CNT_W'(PROG_LAT);
      op_erase_q <= 1'b0;
      op_addr_q  <= prog_addr_i;
      op_data_q  <= prog_data_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
      // the array changes only when the full latency has elapsed
      if (cnt_q == CNT_W'(1)) begin
        if (op_erase_q) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else begin
          mem[op_addr_q] <= mem[op_addr_q] & op_data_q;
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W    = 4,
  parameter int         ERASE_LAT = 24,
  parameter int         PROG_LAT  = 6,
  parameter logic [7:0] MFR_CODE  = 8'h89,
  parameter logic [7:0] DEV_CODE  = 8'hBD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vpp_hi_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              busy_o
);
  logic [ADDR_W-1:0] addr_lat;
  logic [7:0]        wr_data;
  logic              wr_commit;
  mode_e             mode;
  logic [ADDR_W-1:0] ev_addr;
  logic [ADDR_W-1:0] pv_addr;
  logic              erase_go;
  logic              prog_go;
  logic              abort;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;

  flash_bus_capture #(.ADDR_W(ADDR_W)) u_bus (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .addr_i, .data_i,
    .addr_lat_o(addr_lat), .data_o(wr_data), .commit_o(wr_commit)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni, .vpp_hi_i,
    .commit_i(wr_commit), .cmd_i(wr_data), .addr_lat_i(addr_lat), .busy_i(busy_o),
    .mode_o(mode), .ev_addr_o(ev_addr), .pv_addr_o(pv_addr),
    .erase_go_o(erase_go), .prog_go_o(prog_go), .abort_o(abort)
  );

  flash_array_model #(.ADDR_W(ADDR_W), .ERASE_LAT(ERASE_LAT), .PROG_LAT(PROG_LAT)) u_array (
    .clk_i, .rst_ni,
    .erase_go_i(erase_go), .prog_go_i(prog_go), .abort_i(abort),
    .prog_addr_i(addr_lat), .prog_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o
  );

  always_comb begin
    unique case (mode)
      MODE_ERASE_VFY: rd_addr = ev_addr;
      MODE_PROG_VFY:  rd_addr = pv_addr;
      default:        rd_addr = addr_i;
    endcase
  end

  always_comb begin
    data_o = 8'h00;
    if (!ce_ni && !oe_ni) begin
      if (mode == MODE_ID) begin
        if (addr_i == ADDR_W'(0))      data_o = MFR_CODE;
        else if (addr_i == ADDR_W'(1)) data_o = DEV_CODE;
      end else begin
        data_o = rd_data;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vpp_hi_i,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        data_o,
  input logic              busy_o,
  input mode_e             mode,
  input logic              wr_commit,
  input logic              erase_go
);
  a_r2_vpp_low_forces_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vpp_hi_i |=> (mode == MODE_READ));

  a_r4_mfr_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_ID && !ce_ni && !oe_ni && addr_i == ADDR_W'(0)) |-> (data_o == 8'h89));

  a_r13_idle_bus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni) |-> (data_o == 8'h00));

  a_r12_write_stops_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_commit && busy_o) |=> !busy_o);

  a_r5_erase_needs_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_go |-> (mode == MODE_ERASE_SET));

  a_r5_busy_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_commit));
endmodule

bind flash_cmd_top flash_cmd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vpp_hi_i(vpp_hi_i), .ce_ni(ce_ni), .oe_ni(oe_ni),
  .addr_i(addr_i), .data_o(data_o), .busy_o(busy_o), .mode(mode),
  .wr_commit(wr_commit), .erase_go(erase_go)
);

// File: tb/flash_cmd_top_tb.sv
module flash_cmd_top_tb;
  localparam int AW        = 4;
  localparam int DEPTH     = 1 << AW;
  localparam int ERASE_LAT = 24;
  localparam int PROG_LAT  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vpp = 1'b1;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          busy;

  int checks = 0, failures = 0, busy_cyc = 0;
  bit done = 0;
  logic [7:0] ref_mem [DEPTH];

  always #2 clk = ~clk;
  always @(posedge clk) if (busy) busy_cyc++;

  flash_cmd_top #(.ADDR_W(AW), .ERASE_LAT(ERASE_LAT), .PROG_LAT(PROG_LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .vpp_hi_i(vpp), .ce_ni(ce_n), .we_ni(we_n),
    .oe_ni(oe_n), .addr_i(addr), .data_i(din), .data_o(dout), .busy_o(busy)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // decoy address after the fall and decoy data until just before the rise (R11)
  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; addr = a; din = ~d; we_n = 1;
    @(negedge clk); we_n = 0;
    @(negedge clk); addr = ~a;
    @(negedge clk); din = d;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1; addr = '0; din = 8'h5A;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 0; oe_n = 0; addr = a;
    #1 d = dout;
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic sweep(input string req);
    logic [7:0] d;
    for (int a = 0; a < DEPTH; a++) begin
      bus_read(AW'(a), d);
      chk(req, d, ref_mem[a]);
    end
  endtask

  initial begin
    logic [7:0] d;
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R13: outputs idle without both enables
    @(negedge clk); ce_n = 1; oe_n = 0; #1 chk("R13 ce high", dout, 0);
    @(negedge clk); ce_n = 0; oe_n = 1; #1 chk("R13 oe high", dout, 0);
    @(negedge clk); ce_n = 1; oe_n = 1;

    sweep("R1 reset array FF");

    // R8 R9 R11: program each byte, verify through C0 at an unrelated read address
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] pd;
      pd = 8'((a * 37 + 5) & 8'h7F);
      busy_cyc = 0;
      bus_write(AW'(a), 8'h40);
      bus_write(AW'(a), pd);
      wait_idle();
      chk("R8 program busy cycles", busy_cyc, PROG_LAT);
      ref_mem[a] &= pd;
      bus_write(AW'(0), 8'hC0);
      bus_read(AW'(DEPTH - 1 - a), d);
      chk("R9 program verify", d, ref_mem[a]);
    end
    // R8: second program ANDs into existing content
    bus_write(AW'(3), 8'h40);
    bus_write(AW'(3), 8'hF0);
    wait_idle();
    ref_mem[3] &= 8'hF0;
    bus_write(AW'(0), 8'h00);
    sweep("R3 read array after program");
    sweep("R3 read array persists");

    // R7: erase verify reads the latched address
    for (int a = 0; a < DEPTH; a++) begin
      bus_write(AW'(a), 8'hA0);
      bus_read(~AW'(a), d);
      chk("R7 erase verify", d, ref_mem[a]);
    end

    // R4: identifier codes across all addresses
    bus_write(AW'(0), 8'h90);
    for (int a = 0; a < DEPTH; a++) begin
      bus_read(AW'(a), d);
      chk("R4 identifier", d, (a == 0) ? 8'h89 : (a == 1) ? 8'hBD : 8'h00);
    end

    // R10: undefined code drops back to read array
    bus_write(AW'(0), 8'h55);
    bus_read(AW'(0), d); chk("R10 undefined code", d, ref_mem[0]);
    bus_write(AW'(0), 8'h90);
    bus_write(AW'(0), 8'hFF);
    bus_write(AW'(0), 8'hFF);
    bus_read(AW'(1), d); chk("R10 double FF", d, ref_mem[1]);

    // R6: bad erase confirm
    busy_cyc = 0;
    bus_write(AW'(0), 8'h20);
    bus_write(AW'(0), 8'h33);
    repeat (ERASE_LAT + 4) @(negedge clk);
    chk("R6 no erase busy", busy_cyc, 0);
    sweep("R6 array unchanged");

    // R12: write during erase stops it
    bus_write(AW'(0), 8'h20);
    bus_write(AW'(0), 8'h20);
    repeat (2) @(negedge clk);
    chk("R12 erase running", busy, 1);
    bus_write(AW'(5), 8'h90);
    #1 chk("R12 busy cleared", busy, 0);
    repeat (ERASE_LAT + 4) @(negedge clk);
    sweep("R12 array unchanged and mode kept");

    // R2: writes ignored with supply low
    @(negedge clk); vpp = 0;
    busy_cyc = 0;
    bus_write(AW'(2), 8'h40);
    bus_write(AW'(2), 8'h00);
    bus_write(AW'(2), 8'h90);
    repeat (PROG_LAT + 4) @(negedge clk);
    chk("R2 no operation", busy_cyc, 0);
    bus_read(AW'(0), d); chk("R2 no mode change", d, ref_mem[0]);
    bus_read(AW'(2), d); chk("R2 array unchanged", d, ref_mem[2]);

    // R1: supply drop returns to read array
    @(negedge clk); vpp = 1;
    bus_write(AW'(0), 8'h90);
    bus_read(AW'(0), d); chk("R1 id before drop", d, 8'h89);
    @(negedge clk); vpp = 0;
    @(negedge clk); vpp = 1;
    bus_read(AW'(0), d); chk("R1 read array after drop", d, ref_mem[0]);

    // R5: full erase
    busy_cyc = 0;
    bus_write(AW'(0), 8'h20);
    bus_write(AW'(0), 8'h20);
    wait_idle();
    chk("R5 erase busy cycles", busy_cyc, ERASE_LAT);
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = 8'hFF;
    sweep("R5 erased");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule